// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Word

This block is the arithmetic core of a small 8-bit accumulator machine. It holds the accumulator and the B register. On a strobed opcode it performs one of five operations: add, add with carry, subtract with borrow, unsigned multiply or unsigned divide. Each operation updates the carry, half-carry and overflow flags. The unit also keeps the program status word. That word holds two general-purpose flags for software, a two-bit register-bank selector and a parity bit. The parity bit always follows the accumulator.

The surrounding core loads the accumulator and B directly through load ports. It writes the status word as a whole. It reads back the results, the status word and the base address of the selected register bank.

The flag bit positions are fixed, because software decodes them: bit 7 carry, bit 6 half-carry, bit 5 user flag 0, bits 4:3 bank select, bit 2 overflow, bit 1 user flag 1, bit 0 parity.

Top module: `arith_status_unit`

## Requirements
- R1: After reset the accumulator, B and every status-word bit are 0, and the bank base is 0.
- R2: Opcode 0 (add) writes acc+operand to the accumulator. Opcode 1 (add with carry) also adds the current carry flag. Carry is set when the sum exceeds 255 and is cleared otherwise.
- R3: Opcode 2 (subtract with borrow) writes acc-operand-carry, modulo 256, to the accumulator. Carry is set when that difference is negative and is cleared otherwise.
- R4: For opcodes 0 to 2, the half-carry flag is set on a carry out of, or a borrow into, the low nibble. Multiply and divide clear both carry and half-carry.
- R5: For opcodes 0 to 2, overflow is set exactly when the signed two's-complement result leaves -128..127.
- R6: Opcode 3 (multiply) puts the low byte of acc×B in the accumulator and the high byte in B. Overflow is set exactly when the product exceeds 255.
- R7: Opcode 4 (divide) puts acc/B in the accumulator and acc mod B in B, and clears overflow. When B is 0, it sets overflow and leaves both the accumulator and B unchanged.
- R8: Status bit 0 always equals the XOR of the eight accumulator bits. This holds after direct loads too, and a status-word write cannot change it.
- R9: The bank base output equals the bank-select field (status bits 4:3) times 8.
- R10: A status-word write updates bits 7 to 1. No arithmetic operation changes user flags 0 and 1 or the bank select.
- R11: When a status-word write and an operation occur in the same cycle, the operation's carry, half-carry and overflow win, and the write sets the other bits. When a direct load and an operation target the same register, the operation wins.
- R12: Opcodes 5 to 7, and any cycle without the strobe, leave the accumulator, B and the flags unchanged apart from direct loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation select (0 add, 1 add with carry, 2 subtract with borrow, 3 multiply, 4 divide) |
| operand | input | 8 | Second operand for add and subtract |
| accWrEn | input | 1 | Direct accumulator load |
| accWrData | input | 8 | Accumulator load value |
| bWrEn | input | 1 | Direct B load |
| bWrData | input | 8 | B load value |
| pswWrEn | input | 1 | Status-word write |
| pswWrData | input | 8 | Status-word write value (bit 0 ignored) |
| accOut | output | 8 | Accumulator |
| bOut | output | 8 | B register |
| pswOut | output | 8 | Status word |
| bankBase | output | 5 | Base address of the selected register bank |

## Verification
The status-word write and the arithmetic flag update can land in the same cycle. So can a direct register load and an operation result. The random phase drives all three strobes independently, and a directed phase forces each clash with known flag patterns. The bench model resolves each clash by the priority rules. Every clock it compares all bits of the status word against the model, so a lost user flag or a wrong carry winner shows up as a miscompare.

// File: rtl/asu_pkg.sv
package asu_pkg;
  localparam int unsigned BitCy = 7;
  localparam int unsigned BitAc = 6;
  localparam int unsigned BitF0 = 5;
  localparam int unsigned BitRsHi = 4;
  localparam int unsigned BitRsLo = 3;
  localparam int unsigned BitOv = 2;
  localparam int unsigned BitF1 = 1;
  localparam int unsigned BitPar = 0;

  typedef enum logic [2:0] {
    OpAdd  = 3'd0,
    OpAddc = 3'd1,
    OpSubb = 3'd2,
    OpMul  = 3'd3,
    OpDiv  = 3'd4
  } asu_op_e;

  typedef struct packed {
    logic arith;
    logic withCarry;
    logic subtract;
    logic mul;
    logic div;
  } asu_strobe_t;
endpackage

// File: rtl/asu_ctrl.sv
module asu_ctrl
  import asu_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opCode,
  output asu_strobe_t stb
);
  always_comb begin
    stb = '0;
    if (opValid) begin
      unique case (opCode)
        OpAdd:   stb.arith = 1'b1;
        OpAddc:  begin stb.arith = 1'b1; stb.withCarry = 1'b1; end
        OpSubb:  begin stb.arith = 1'b1; stb.withCarry = 1'b1; stb.subtract = 1'b1; end
        OpMul:   stb.mul = 1'b1;
        OpDiv:   stb.div = 1'b1;
        default: stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/asu_datapath.sv
module asu_datapath
  import asu_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned BankRegs = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  asu_strobe_t                    stb,
  input  logic [W-1:0]                   operand,
  input  logic                           accWrEn,
  input  logic [W-1:0]                   accWrData,
  input  logic                           bWrEn,
  input  logic [W-1:0]                   bWrData,
  input  logic                           pswWrEn,
  input  logic [7:0]                     pswWrData,
  output logic [W-1:0]                   accOut,
  output logic [W-1:0]                   bOut,
  output logic [7:0]                     pswOut,
  output logic [$clog2(BankRegs)+1:0]    bankBase
);
  localparam int unsigned Half = W / 2;
  localparam int unsigned Shift = $clog2(BankRegs);

  logic [W-1:0] accQ, bQ;
  logic cyQ, acQ, ovQ, f0Q, f1Q;
  logic [1:0] rsQ;

  logic carryIn, cOut, hOut, vOut, divZero;
  logic [W-1:0] addend, quot, rem;
  logic [W:0] sumWide;
  logic [Half:0] nibWide;
  logic [2*W-1:0] product;

  always_comb begin
    addend  = stb.subtract ? ~operand : operand;
    carryIn = stb.subtract ? ~(stb.withCarry & cyQ) : (stb.withCarry & cyQ);
    sumWide = {1'b0, accQ} + {1'b0, addend} + {{W{1'b0}}, carryIn};
    nibWide = {1'b0, accQ[Half-1:0]} + {1'b0, addend[Half-1:0]} + {{Half{1'b0}}, carryIn};
    cOut    = sumWide[W] ^ stb.subtract;
    hOut    = nibWide[Half] ^ stb.subtract;
    vOut    = (accQ[W-1] == addend[W-1]) && (sumWide[W-1] != accQ[W-1]);
    product = {{W{1'b0}}, accQ} * {{W{1'b0}}, bQ};
    divZero = (bQ == '0);
    quot    = divZero ? accQ : accQ / bQ;
    rem     = divZero ? bQ : accQ % bQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0; bQ <= '0;
      cyQ <= 1'b0; acQ <= 1'b0; ovQ <= 1'b0;
      f0Q <= 1'b0; f1Q <= 1'b0; rsQ <= 2'b00;
    end else begin
      if (accWrEn) accQ <= accWrData;
      if (bWrEn) bQ <= bWrData;
      if (pswWrEn) begin
        cyQ <= pswWrData[BitCy];
        acQ <= pswWrData[BitAc];
        f0Q <= pswWrData[BitF0];
        rsQ <= pswWrData[BitRsHi:BitRsLo];
        ovQ <= pswWrData[BitOv];
        f1Q <= pswWrData[BitF1];
      end
      if (stb.arith) begin
        accQ <= sumWide[W-1:0];
        cyQ <= cOut; acQ <= hOut; ovQ <= vOut;
      end else if (stb.mul) begin
        accQ <= product[W-1:0];
        bQ <= product[2*W-1:W];
        cyQ <= 1'b0; acQ <= 1'b0;
        ovQ <= |product[2*W-1:W];
      end else if (stb.div) begin
        accQ <= quot; bQ <= rem;
        cyQ <= 1'b0; acQ <= 1'b0;
        ovQ <= divZero;
      end
    end
  end

  assign accOut = accQ;
  assign bOut = bQ;
  assign pswOut = {cyQ, acQ, f0Q, rsQ, ovQ, f1Q, ^accQ};
  assign bankBase = {rsQ, {Shift{1'b0}}};
endmodule

// File: rtl/arith_status_unit.sv
module arith_status_unit
  import asu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic [7:0] operand,
  input  logic       accWrEn,
  input  logic [7:0] accWrData,
  input  logic       bWrEn,
  input  logic [7:0] bWrData,
  input  logic       pswWrEn,
  input  logic [7:0] pswWrData,
  output logic [7:0] accOut,
  output logic [7:0] bOut,
  output logic [7:0] pswOut,
  output logic [4:0] bankBase
);
  asu_strobe_t stb;

  asu_ctrl u_ctrl (.opValid(opValid), .opCode(opCode), .stb(stb));

  asu_datapath #(.W(8), .BankRegs(8)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .operand(operand),
    .accWrEn(accWrEn), .accWrData(accWrData),
    .bWrEn(bWrEn), .bWrData(bWrData),
    .pswWrEn(pswWrEn), .pswWrData(pswWrData),
    .accOut(accOut), .bOut(bOut), .pswOut(pswOut), .bankBase(bankBase)
  );
endmodule

// File: rtl/asu_checker.sv
module asu_checker (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [2:0] opCode,
  input logic       pswWrEn,
  input logic [7:0] accOut,
  input logic [7:0] bOut,
  input logic [7:0] pswOut,
  input logic [4:0] bankBase
);
  p_parity_r8: assert property (@(posedge clk) disable iff (!rstN)
    pswOut[0] == ^accOut);

  p_bank_base_r9: assert property (@(posedge clk) disable iff (!rstN)
    bankBase == {pswOut[4:3], 3'b000});

  p_mul_ov_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd3) |=>
      pswOut[2] == ((16'($past(accOut)) * 16'($past(bOut))) > 16'd255));

  p_div_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd4 && bOut == 8'd0) |=>
      (pswOut[2] && $stable(accOut) && $stable(bOut)));

  p_user_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pswWrEn |=> $stable({pswOut[5:3], pswOut[1]}));

  p_idle_flags_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !pswWrEn) |=> $stable({pswOut[7:6], pswOut[2]}));
endmodule

bind arith_status_unit asu_checker u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .pswWrEn(pswWrEn), .accOut(accOut), .bOut(bOut),
  .pswOut(pswOut), .bankBase(bankBase)
);

// File: tb/arith_status_unit_test.sv
module arith_status_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0, accWrEn = 1'b0, bWrEn = 1'b0, pswWrEn = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic [7:0] operand = 8'd0, accWrData = 8'd0, bWrData = 8'd0, pswWrData = 8'd0;
  logic [7:0] accOut, bOut, pswOut;
  logic [4:0] bankBase;

  int vectors = 0;
  int fails = 0;
  int mA = 0, mB = 0;
  int mCy = 0, mAc = 0, mOv = 0, mF0 = 0, mF1 = 0, mRs = 0;

  always #5 clk = ~clk;

  arith_status_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .operand(operand),
    .accWrEn(accWrEn), .accWrData(accWrData), .bWrEn(bWrEn), .bWrData(bWrData),
    .pswWrEn(pswWrEn), .pswWrData(pswWrData),
    .accOut(accOut), .bOut(bOut), .pswOut(pswOut), .bankBase(bankBase)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int parityOf(input int v);
    int p = 0;
    for (int i = 0; i < 8; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  task automatic checkAll();
    cmp("R2 R3 R6 R7 R12 acc", int'(accOut), mA);
    cmp("R6 R7 R12 b", int'(bOut), mB);
    cmp("R2 R3 R11 carry", int'(pswOut[7]), mCy);
    cmp("R4 R11 half-carry", int'(pswOut[6]), mAc);
    cmp("R5 R6 R7 R11 overflow", int'(pswOut[2]), mOv);
    cmp("R10 R11 user flag 0", int'(pswOut[5]), mF0);
    cmp("R10 R11 user flag 1", int'(pswOut[1]), mF1);
    cmp("R10 bank select", int'(pswOut[4:3]), mRs);
    cmp("R8 parity", int'(pswOut[0]), parityOf(mA));
    cmp("R9 bank base", int'(bankBase), mRs * 8);
  endtask

  // One cycle: check at the falling edge, drive inputs, advance the model.
  task automatic step(input bit v, input int op, input int x,
                      input bit aw, input int ad, input bit bw, input int bd,
                      input bit pw, input int pd);
    int nA, nB, s, sa, sx, ss, p;
    @(negedge clk);
    checkAll();
    opValid = v; opCode = 3'(op); operand = 8'(x);
    accWrEn = aw; accWrData = 8'(ad); bWrEn = bw; bWrData = 8'(bd);
    pswWrEn = pw; pswWrData = 8'(pd);
    nA = aw ? ad : mA;
    nB = bw ? bd : mB;
    sa = (mA > 127) ? mA - 256 : mA;
    sx = (x > 127) ? x - 256 : x;
    if (pw) begin
      mCy = (pd >> 7) & 1; mAc = (pd >> 6) & 1; mF0 = (pd >> 5) & 1;
      mRs = (pd >> 3) & 3; mOv = (pd >> 2) & 1; mF1 = (pd >> 1) & 1;
    end
    if (v && op <= 1) begin
      s = (op == 1) ? mCyOld : 0;
      ss = sa + sx + s;
      mAc = (((mA & 15) + (x & 15) + s) > 15) ? 1 : 0;
      s = mA + x + s;
      nA = s & 255; mCy = (s > 255) ? 1 : 0;
      mOv = (ss > 127 || ss < -128) ? 1 : 0;
    end else if (v && op == 2) begin
      ss = sa - sx - mCyOld;
      mAc = (((mA & 15) - (x & 15) - mCyOld) < 0) ? 1 : 0;
      s = mA - x - mCyOld;
      nA = s & 255; mCy = (s < 0) ? 1 : 0;
      mOv = (ss > 127 || ss < -128) ? 1 : 0;
    end else if (v && op == 3) begin
      p = mA * mB;
      nA = p & 255; nB = p >> 8;
      mCy = 0; mAc = 0; mOv = (p > 255) ? 1 : 0;
    end else if (v && op == 4) begin
      mCy = 0; mAc = 0;
      if (mB == 0) begin
        mOv = 1; nA = mA; nB = mB;
      end else begin
        mOv = 0; nA = mA / mB; nB = mA % mB;
      end
    end
    mA = nA; mB = nB; mCyOld = mCy;
  endtask

  int mCyOld = 0;

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll(); // R1 reset values
    rstN = 1'b1;
    // R2 add with carry-out and R4 half-carry, R5 signed overflow
    step(0, 0, 0, 1, 8'h7F, 1, 8'h00, 0, 0);
    step(1, 0, 8'h01, 0, 0, 0, 0, 0, 0);      // 0x7F+1: OV, AC
    step(1, 0, 8'h80, 0, 0, 0, 0, 0, 0);      // 0x80+0x80: CY, OV
    step(1, 1, 8'h0F, 0, 0, 0, 0, 0, 0);      // R2 add with carry uses CY
    // R3 subtract with borrow
    step(0, 0, 0, 1, 8'h10, 0, 0, 1, 8'h80);  // set carry via write
    step(1, 2, 8'h20, 0, 0, 0, 0, 0, 0);      // 0x10-0x20-1
    step(1, 2, 8'h01, 0, 0, 0, 0, 0, 0);
    // R6 multiply small and large
    step(0, 0, 0, 1, 8'd12, 1, 8'd10, 0, 0);
    step(1, 3, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 8'd200, 1, 8'd3, 0, 0);
    step(1, 3, 0, 0, 0, 0, 0, 0, 0);
    // R7 divide normal and by zero
    step(0, 0, 0, 1, 8'd251, 1, 8'd7, 0, 0);
    step(1, 4, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 8'd0, 0, 0);
    step(1, 4, 0, 0, 0, 0, 0, 0, 0);
    // R9 R10 all bank selects, user flags, parity bit written as 1 (R8)
    for (int r = 0; r < 4; r++) step(0, 0, 0, 0, 0, 0, 0, 1, (r << 3) | 8'h23);
    // R11 write and operation in the same cycle, load and operation clash
    step(1, 0, 8'hFF, 1, 8'h55, 0, 0, 1, 8'h7E);
    step(1, 3, 0, 1, 8'h01, 1, 8'h02, 1, 8'hC4);
    // R12 undefined opcodes
    for (int o = 5; o < 8; o++) step(1, o, 8'hAA, 0, 0, 0, 0, 0, 0);
    // Random phase with independent strobes
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, $urandom % 8, $urandom % 256,
           ($urandom % 3) == 0, $urandom % 256,
           ($urandom % 4) == 0, (($urandom % 4) == 0) ? 0 : $urandom % 256,
           ($urandom % 5) == 0, $urandom % 256);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    checkAll();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule